// File: doc/BRIEF.md
# Dual-Reset Wake-Context Configuration Register Bank

This block is a small byte-addressed configuration register bank for a peripheral that can signal a power-management wake-up. It takes two resets. The global reset is an asynchronous, active-low power-on reset that returns every bit to its default value. The bus reset is a synchronous, active-low reset issued by the host bus. A subset of bits are wake-context bits. A bus reset leaves them untouched while wake signalling is enabled, and clears them otherwise.

The bank also holds a group of general-purpose event cells. Each cell has a sticky status bit, set from a hardware event input and cleared by writing 1, and an enable bit. Any cell whose status and enable are both set raises the event output. A separate wake-status bit, qualified by the wake-enable bit, drives the wake output.

Top module: `wake_ctx_regbank`

## Requirements
- R1: After global reset (`rst_ni` low) every mapped byte reads 0x00, and `evt_o` and `wake_o` are low.
- R2: With wake-enable (bit 0 of byte 0xA5) set, a bus reset cycle leaves all wake-context bits unchanged. The wake-context bits are bit 6 of byte 0x3E, bits 2:0 of byte 0x81, and wake status (bit 7 of byte 0xA5).
- R3: With wake-enable clear, a bus reset cycle clears all wake-context bits to 0.
- R4: A bus reset cycle clears every non-context bit, whatever the wake-enable state. Non-context bits are all bits of bytes 0x80, 0x88, 0x89 and 0xA4, plus the other bits of 0x3E and 0x81. The same reset cycle also drops `evt_o`.
- R5: Wake-enable is changed only by a write to byte 0xA5 bit 0 or by global reset. A bus reset never alters it.
- R6: Event status byte 0x88: `evt_i[k]` high at a clock edge sets bit k. Writing 1 to bit k clears it, and writing 0 has no effect.
- R7: Event enable byte 0x89 is read/write in bits NUM_EVT-1:0. `evt_o` is high exactly when some bit k has both status and enable set.
- R8: Wake status (0xA5 bit 7) is set by `wake_evt_i` and cleared by writing 1 to it. `wake_o` is high when wake status and wake-enable are both set.
- R9: When an event input (or `wake_evt_i`) is high in the same cycle as a write-1-to-clear of its bit, the bit stays set.
- R10: Unmapped addresses read 0x00 and writes to them have no effect. Bits 6:1 of 0xA5 and event bits at or above NUM_EVT read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Global power-on reset, asynchronous, active low |
| bus_rst_ni | input | 1 | Bus reset, synchronous, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration byte address |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data for `cfg_addr_i` (combinational) |
| evt_i | input | NUM_EVT | Hardware event inputs, one per status cell |
| wake_evt_i | input | 1 | Hardware wake event, sets wake status |
| evt_o | output | 1 | OR of all enabled, pending event cells |
| wake_o | output | 1 | Wake request output |

## Verification
The bench builds the block with NUM_EVT = 4. This leaves bits 7:4 of the event bytes unimplemented, so the bench can check that those bits read zero. It also leaves a mix of enabled and disabled cells for the event OR. With that width, the bench runs the bus reset with wake-enable both set and clear against the same pattern of written bytes. This separates context bits from non-context bits within one byte. The bench also places event pulses in the same cycle as clearing writes.

// File: rtl/wake_ctx_pkg.sv
package wake_ctx_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADR_BRIDGE  = 8'h3E;
  localparam logic [ADDR_W-1:0] ADR_SYS_LO  = 8'h80;
  localparam logic [ADDR_W-1:0] ADR_SYS_HI  = 8'h81;
  localparam logic [ADDR_W-1:0] ADR_EVT_ST  = 8'h88;
  localparam logic [ADDR_W-1:0] ADR_EVT_EN  = 8'h89;
  localparam logic [ADDR_W-1:0] ADR_PM_LO   = 8'hA4;
  localparam logic [ADDR_W-1:0] ADR_PM_HI   = 8'hA5;

  localparam logic [DATA_W-1:0] CTX_BRIDGE  = 8'h40;
  localparam logic [DATA_W-1:0] CTX_SYS_HI  = 8'h07;
  localparam logic [DATA_W-1:0] CTX_NONE    = 8'h00;

  localparam int unsigned WAKE_EN_BIT   = 0;
  localparam int unsigned WAKE_STAT_BIT = 7;
  localparam int unsigned CTX_W         = 5;
endpackage

// File: rtl/wake_ctx_byte_reg.sv
module wake_ctx_byte_reg
  import wake_ctx_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_VAL = '0,
  parameter logic [DATA_W-1:0] CTX_MASK  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_rst_i,
  input  logic              keep_ctx_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q;
  logic [DATA_W-1:0] bus_rst_val;

  always_comb begin
    if (keep_ctx_i) bus_rst_val = (q & CTX_MASK) | (RESET_VAL & ~CTX_MASK);
    else            bus_rst_val = RESET_VAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q <= RESET_VAL;
    else if (bus_rst_i) q <= bus_rst_val;
    else if (we_i)      q <= wdata_i;
  end

  assign q_o = q;
endmodule

// File: rtl/wake_ctx_evt_cell.sv
module wake_ctx_evt_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_rst_i,
  input  logic set_i,
  input  logic w1c_i,
  input  logic en_we_i,
  input  logic en_wdata_i,
  output logic stat_o,
  output logic en_o,
  output logic evt_o
);
  logic stat_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= 1'b0;
      en_q   <= 1'b0;
    end else if (bus_rst_i) begin
      stat_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      // set beats clear
      if (set_i)      stat_q <= 1'b1;
      else if (w1c_i) stat_q <= 1'b0;
      if (en_we_i)    en_q   <= en_wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign evt_o  = stat_q & en_q;
endmodule

// File: rtl/wake_ctx_regbank.sv
module wake_ctx_regbank
  import wake_ctx_pkg::*;
#(
  parameter int unsigned NUM_EVT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_rst_ni,
  input  logic               cfg_we_i,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic [DATA_W-1:0]  cfg_wdata_i,
  output logic [DATA_W-1:0]  cfg_rdata_o,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               wake_evt_i,
  output logic               evt_o,
  output logic               wake_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_EVT;

  initial begin
    if (NUM_EVT < 1 || NUM_EVT > DATA_W) $error("NUM_EVT out of range");
  end

  logic bus_rst;
  logic wake_en_q, wake_stat_q;
  logic [DATA_W-1:0] bridge_q, sys_lo_q, sys_hi_q, pm_lo_q;
  logic [NUM_EVT-1:0] evt_stat, evt_en, evt_hit;
  logic [CTX_W-1:0] ctx_vec;
  logic wr_bridge, wr_sys_lo, wr_sys_hi, wr_pm_lo, wr_pm_hi, wr_evt_st, wr_evt_en;

  assign bus_rst   = !bus_rst_ni;
  assign wr_bridge = cfg_we_i && cfg_addr_i == ADR_BRIDGE;
  assign wr_sys_lo = cfg_we_i && cfg_addr_i == ADR_SYS_LO;
  assign wr_sys_hi = cfg_we_i && cfg_addr_i == ADR_SYS_HI;
  assign wr_pm_lo  = cfg_we_i && cfg_addr_i == ADR_PM_LO;
  assign wr_pm_hi  = cfg_we_i && cfg_addr_i == ADR_PM_HI;
  assign wr_evt_st = cfg_we_i && cfg_addr_i == ADR_EVT_ST;
  assign wr_evt_en = cfg_we_i && cfg_addr_i == ADR_EVT_EN;

  wake_ctx_byte_reg #(.RESET_VAL(8'h00), .CTX_MASK(CTX_BRIDGE)) u_bridge (
    .clk_i, .rst_ni, .bus_rst_i(bus_rst), .keep_ctx_i(wake_en_q),
    .we_i(wr_bridge), .wdata_i(cfg_wdata_i), .q_o(bridge_q));

  wake_ctx_byte_reg #(.RESET_VAL(8'h00), .CTX_MASK(CTX_NONE)) u_sys_lo (
    .clk_i, .rst_ni, .bus_rst_i(bus_rst), .keep_ctx_i(wake_en_q),
    .we_i(wr_sys_lo), .wdata_i(cfg_wdata_i), .q_o(sys_lo_q));

  wake_ctx_byte_reg #(.RESET_VAL(8'h00), .CTX_MASK(CTX_SYS_HI)) u_sys_hi (
    .clk_i, .rst_ni, .bus_rst_i(bus_rst), .keep_ctx_i(wake_en_q),
    .we_i(wr_sys_hi), .wdata_i(cfg_wdata_i), .q_o(sys_hi_q));

  wake_ctx_byte_reg #(.RESET_VAL(8'h00), .CTX_MASK(CTX_NONE)) u_pm_lo (
    .clk_i, .rst_ni, .bus_rst_i(bus_rst), .keep_ctx_i(wake_en_q),
    .we_i(wr_pm_lo), .wdata_i(cfg_wdata_i), .q_o(pm_lo_q));

  // wake enable: global reset only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 wake_en_q <= 1'b0;
    else if (!bus_rst && wr_pm_hi) wake_en_q <= cfg_wdata_i[WAKE_EN_BIT];
  end

  // wake status: context bit, W1C, set wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_stat_q <= 1'b0;
    else if (bus_rst) begin
      if (!wake_en_q) wake_stat_q <= 1'b0;
    end else if (wake_evt_i) wake_stat_q <= 1'b1;
    else if (wr_pm_hi && cfg_wdata_i[WAKE_STAT_BIT]) wake_stat_q <= 1'b0;
  end

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_evt
    wake_ctx_evt_cell u_cell (
      .clk_i, .rst_ni,
      .bus_rst_i (bus_rst),
      .set_i     (evt_i[k]),
      .w1c_i     (wr_evt_st && cfg_wdata_i[k]),
      .en_we_i   (wr_evt_en),
      .en_wdata_i(cfg_wdata_i[k]),
      .stat_o    (evt_stat[k]),
      .en_o      (evt_en[k]),
      .evt_o     (evt_hit[k]));
  end

  assign evt_o  = |evt_hit;
  assign wake_o = wake_stat_q & wake_en_q;
  assign ctx_vec = {bridge_q[6], sys_hi_q[2:0], wake_stat_q};

  logic [DATA_W-1:0] evt_stat_rd, evt_en_rd, pm_hi_rd;
  generate
    if (PAD_W > 0) begin : g_pad
      assign evt_stat_rd = {{PAD_W{1'b0}}, evt_stat};
      assign evt_en_rd   = {{PAD_W{1'b0}}, evt_en};
    end else begin : g_nopad
      assign evt_stat_rd = evt_stat;
      assign evt_en_rd   = evt_en;
    end
  endgenerate

  always_comb begin
    pm_hi_rd = '0;
    pm_hi_rd[WAKE_EN_BIT]   = wake_en_q;
    pm_hi_rd[WAKE_STAT_BIT] = wake_stat_q;
  end

  always_comb begin
    case (cfg_addr_i)
      ADR_BRIDGE: cfg_rdata_o = bridge_q;
      ADR_SYS_LO: cfg_rdata_o = sys_lo_q;
      ADR_SYS_HI: cfg_rdata_o = sys_hi_q;
      ADR_EVT_ST: cfg_rdata_o = evt_stat_rd;
      ADR_EVT_EN: cfg_rdata_o = evt_en_rd;
      ADR_PM_LO:  cfg_rdata_o = pm_lo_q;
      ADR_PM_HI:  cfg_rdata_o = pm_hi_rd;
      default:    cfg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wake_ctx_chk.sv
module wake_ctx_chk
  import wake_ctx_pkg::*;
#(
  parameter int unsigned NUM_EVT = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_rst_ni,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               evt_o,
  input logic               wake_en,
  input logic [CTX_W-1:0]   ctx_vec,
  input logic [NUM_EVT-1:0] evt_stat
);
  AST_CTX_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_rst_ni && wake_en) |=> ctx_vec == $past(ctx_vec)); // R2
  AST_CTX_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_rst_ni && !wake_en) |=> ctx_vec == '0); // R3
  AST_BUSRST_EVT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rst_ni |=> !evt_o); // R4
  AST_WAKE_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rst_ni |=> wake_en == $past(wake_en)); // R5
  AST_EVT_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rst_ni && |evt_i) |=> (evt_stat & $past(evt_i)) == $past(evt_i)); // R9
endmodule

bind wake_ctx_regbank wake_ctx_chk #(.NUM_EVT(NUM_EVT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_rst_ni (bus_rst_ni),
  .evt_i      (evt_i),
  .evt_o      (evt_o),
  .wake_en    (wake_en_q),
  .ctx_vec    (ctx_vec),
  .evt_stat   (evt_stat)
);

// File: tb/wake_ctx_regbank_tb_top.sv
module wake_ctx_regbank_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NUM_EVT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rst_n = 1'b1;
  logic we = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [NUM_EVT-1:0] evt = '0;
  logic wake_evt = 1'b0;
  logic evt_out, wake_out;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_ctx_regbank #(.NUM_EVT(NUM_EVT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_rst_ni(bus_rst_n),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .evt_i(evt), .wake_evt_i(wake_evt), .evt_o(evt_out), .wake_o(wake_out));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_check(string req, logic [7:0] a, logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    check(req, rdata, exp);
  endtask

  task automatic bus_reset();
    @(negedge clk); bus_rst_n = 1'b0;
    @(negedge clk); bus_rst_n = 1'b1;
  endtask

  task automatic wake_pulse();
    @(negedge clk); wake_evt = 1'b1;
    @(negedge clk); wake_evt = 1'b0;
  endtask

  task automatic glob_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    glob_reset();
    rd_check("R1 bridge", 8'h3E, 8'h00);
    rd_check("R1 sys_lo", 8'h80, 8'h00);
    rd_check("R1 sys_hi", 8'h81, 8'h00);
    rd_check("R1 evt_st", 8'h88, 8'h00);
    rd_check("R1 evt_en", 8'h89, 8'h00);
    rd_check("R1 pm_lo",  8'hA4, 8'h00);
    rd_check("R1 pm_hi",  8'hA5, 8'h00);
    check("R1 evt_o",  {7'b0, evt_out},  8'h00);
    check("R1 wake_o", {7'b0, wake_out}, 8'h00);
  endtask

  task automatic load_pattern();
    wr(8'h3E, 8'hFF); wr(8'h80, 8'hAA); wr(8'h81, 8'hFF); wr(8'hA4, 8'h55);
    wr(8'h89, 8'h0F);
    @(negedge clk); evt = 4'hF;
    @(negedge clk); evt = 4'h0;
    wake_pulse();
  endtask

  task automatic t_keep_ctx();
    wr(8'hA5, 8'h01);
    load_pattern();
    rd_check("R8 wake status set", 8'hA5, 8'h81);
    check("R8 wake_o high", {7'b0, wake_out}, 8'h01);
    bus_reset();
    rd_check("R2 bridge ctx kept", 8'h3E, 8'h40);
    rd_check("R2 sys_hi ctx kept", 8'h81, 8'h07);
    rd_check("R2 R5 pm_hi kept",   8'hA5, 8'h81);
    rd_check("R4 sys_lo cleared",  8'h80, 8'h00);
    rd_check("R4 pm_lo cleared",   8'hA4, 8'h00);
    rd_check("R4 evt_st cleared",  8'h88, 8'h00);
    rd_check("R4 evt_en cleared",  8'h89, 8'h00);
    check("R4 evt_o low", {7'b0, evt_out}, 8'h00);
    check("R2 wake_o kept", {7'b0, wake_out}, 8'h01);
  endtask

  task automatic t_clear_ctx();
    wr(8'hA5, 8'h80); // clear status, disable
    rd_check("R8 w1c wake status", 8'hA5, 8'h00);
    load_pattern();
    rd_check("R8 status w/o enable", 8'hA5, 8'h80);
    check("R8 wake_o needs enable", {7'b0, wake_out}, 8'h00);
    bus_reset();
    rd_check("R3 bridge cleared", 8'h3E, 8'h00);
    rd_check("R3 sys_hi cleared", 8'h81, 8'h00);
    rd_check("R3 pm_hi cleared",  8'hA5, 8'h00);
  endtask

  task automatic t_events();
    @(negedge clk); evt = 4'b0101;
    @(negedge clk); evt = 4'b0000;
    rd_check("R6 status set", 8'h88, 8'h05);
    check("R7 evt_o low, none enabled", {7'b0, evt_out}, 8'h00);
    wr(8'h89, 8'hFF);
    rd_check("R7 en readback masked R10", 8'h89, 8'h0F);
    check("R7 evt_o high", {7'b0, evt_out}, 8'h01);
    wr(8'h88, 8'h00);
    rd_check("R6 write 0 no effect", 8'h88, 8'h05);
    wr(8'h88, 8'h01);
    rd_check("R6 w1c one bit", 8'h88, 8'h04);
    wr(8'h89, 8'h02);
    check("R7 evt_o low, pending bit disabled", {7'b0, evt_out}, 8'h00);
    // R9: set and clear in same cycle
    @(negedge clk); we = 1'b1; addr = 8'h88; wdata = 8'h02; evt = 4'b0010;
    @(negedge clk); we = 1'b0; evt = 4'b0000;
    rd_check("R9 set beats clear", 8'h88, 8'h06);
    check("R7 evt_o with enabled pending", {7'b0, evt_out}, 8'h01);
    // R9 for wake status
    wr(8'hA5, 8'h01);
    @(negedge clk); we = 1'b1; addr = 8'hA5; wdata = 8'h81; wake_evt = 1'b1;
    @(negedge clk); we = 1'b0; wake_evt = 1'b0;
    rd_check("R9 wake set beats clear", 8'hA5, 8'h81);
  endtask

  task automatic t_unmapped();
    wr(8'h10, 8'hFF);
    rd_check("R10 unmapped reads 0", 8'h10, 8'h00);
    wr(8'hA5, 8'hFE); // clear status, disable, reserved ones
    rd_check("R10 pm_hi reserved 0", 8'hA5, 8'h00);
    rd_check("R10 neighbours intact", 8'h88, 8'h06);
  endtask

  task automatic t_global_clears_ctx();
    wr(8'hA5, 8'h01); wr(8'h3E, 8'h40); wake_pulse();
    glob_reset();
    rd_check("R1 R5 global clears enable", 8'hA5, 8'h00);
    rd_check("R1 global clears ctx", 8'h3E, 8'h00);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset_state();
    t_keep_ctx();
    t_clear_ctx();
    t_events();
    t_unmapped();
    t_global_clears_ctx();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule